// File: doc/BRIEF.md
# Masked Interrupt Request Register Bank

This block sits inside a peripheral and collects its interrupt events into five priority levels. Each level owns a 32-bit pending register and a 32-bit enable-blocking register. A one-cycle pulse on a source line latches the matching pending bit. A pending bit stays latched until software clears it by writing a one to that bit position.

For every level, the pending bits that are not blocked are OR-ed into a single flag. The five flags form a registered level vector, which a chip-level aggregator combines with the vectors of other peripherals. Level 0 is the most urgent and level 4 the least urgent. Software reads this vector first and then reads the pending register of the chosen level to find the source.

All ten registers are reachable over a simple word-addressed register bus. Writes take effect on the clock edge. Read data is combinational from the address.

Top module: `irq_level_bank`

## Requirements
- R1: After reset every pending register reads 0, every blocking register reads 32'hFFFF_FFFF, and `level_out` is 0.
- R2: A one on `src_set[n*32+b]` during a clock edge sets bit b of pending register n. That register is read at word offset n (0 to 4), and the bit is visible from the next cycle.
- R3: A write to offset n (0 to 4) clears each pending bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: When a source pulse and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R5: Blocking register n sits at word offset 8+n. A write replaces its full 32-bit value, and a read returns that value.
- R6: A blocking bit of 1 keeps the pending bit at the same position out of the level flag. With all bits of level n blocked, `level_out[n]` stays 0 whatever is pending.
- R7: `level_out[n]` is 1 exactly when pending register n has at least one bit whose blocking bit is 0. Bit 0 of the vector belongs to the most urgent level, and the levels do not affect each other.
- R8: `level_out` is a register. It reflects pending and blocking state one clock edge after that state changes.
- R9: Offsets 5 to 7 and 13 to 15 read as 0. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_set | input | 160 | One-cycle source pulses; bit n*32+b targets level n, bit b |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| level_out | output | 5 | Registered per-level flag vector, bit 0 most urgent |

## Verification
The bench hits the same pending bit with a source pulse and a clearing write in one cycle. A design that lets the clear win would lose that event. It writes partial clear masks, which catches a design that clears the whole register instead of only the bits written as one. It samples `level_out` on the edge where a blocking or pending change lands, then again one edge later. A combinational or two-stage flag path shows up as an early or late change. It also writes all ones to the holes in the map and reads them back. It then re-reads the live registers, which exposes aliasing from a decoder that drops address bits.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

   localparam int unsigned SLOT_IDX_W = 8;

   typedef enum logic [1:0] {
      SLOT_NONE = 2'd0,
      SLOT_REQ  = 2'd1,
      SLOT_MASK = 2'd2
   } slot_kind_e;

   typedef struct packed {
      slot_kind_e            kind;
      logic [SLOT_IDX_W-1:0] idx;
   } slot_t;

   // Map a word offset onto a pending slot, a blocking slot or nothing.
   function automatic slot_t decode_slot(input int unsigned addr,
                                         input int unsigned levels,
                                         input int unsigned mask_base);
      slot_t s;
      s.kind = SLOT_NONE;
      s.idx  = '0;
      if (addr < levels) begin
         s.kind = SLOT_REQ;
         s.idx  = SLOT_IDX_W'(addr);
      end else if (addr >= mask_base && addr < mask_base + levels) begin
         s.kind = SLOT_MASK;
         s.idx  = SLOT_IDX_W'(addr - mask_base);
      end
      return s;
   endfunction

endpackage

// File: rtl/irq_level_slice.sv
// One priority level: pending register, blocking register and the
// unblocked-reduction flag (combinational; registered by the top).
module irq_level_slice #(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set_pulse,
   input  logic             req_wr,
   input  logic             mask_wr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] req_q,
   output logic [REG_W-1:0] mask_q,
   output logic             active
);

   logic [REG_W-1:0] clr_bits;
   logic [REG_W-1:0] req_d;

   assign clr_bits = req_wr ? wdata : '0;
   // Source pulses are OR-ed after the clear so they win a collision.
   assign req_d    = (req_q & ~clr_bits) | set_pulse;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= '0;
         mask_q <= '1;
      end else begin
         req_q <= req_d;
         if (mask_wr) begin
            mask_q <= wdata;
         end
      end
   end

   assign active = |(req_q & ~mask_q);

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
   import irq_bank_pkg::*;
#(
   parameter int NUM_LEVELS = 5,
   parameter int REG_W      = 32,
   parameter int ADDR_W     = 4,
   parameter int MASK_BASE  = 8,
   localparam int FLAT_W    = NUM_LEVELS * REG_W
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [FLAT_W-1:0] req_flat,
   input  logic [FLAT_W-1:0] mask_flat,
   output logic [REG_W-1:0]  rdata
);

   slot_t slot;

   always_comb begin
      slot  = decode_slot(32'(addr), NUM_LEVELS, MASK_BASE);
      rdata = '0;
      for (int i = 0; i < NUM_LEVELS; i++) begin
         if (slot.idx == SLOT_IDX_W'(i)) begin
            if (slot.kind == SLOT_REQ) begin
               rdata = req_flat[i*REG_W +: REG_W];
            end else if (slot.kind == SLOT_MASK) begin
               rdata = mask_flat[i*REG_W +: REG_W];
            end
         end
      end
   end

endmodule

// File: rtl/irq_level_bank.sv
module irq_level_bank
   import irq_bank_pkg::*;
#(
   parameter int NUM_LEVELS = 5,
   parameter int REG_W      = 32,
   parameter int ADDR_W     = 4,
   parameter int MASK_BASE  = 8,
   localparam int FLAT_W    = NUM_LEVELS * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAT_W-1:0] src_set,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [NUM_LEVELS-1:0] level_out
);

   // Elaboration-time parameter checks.
   if (NUM_LEVELS < 1 || NUM_LEVELS > (1 << SLOT_IDX_W)) begin : g_bad_levels
      $error("irq_level_bank: NUM_LEVELS out of range");
   end
   if (MASK_BASE < NUM_LEVELS) begin : g_bad_base
      $error("irq_level_bank: blocking block overlaps pending block");
   end
   if (MASK_BASE + NUM_LEVELS > (1 << ADDR_W)) begin : g_bad_addr
      $error("irq_level_bank: ADDR_W too narrow for the map");
   end
   if (REG_W < 1) begin : g_bad_width
      $error("irq_level_bank: REG_W must be positive");
   end

   slot_t                 wslot;
   logic [NUM_LEVELS-1:0] req_wr;
   logic [NUM_LEVELS-1:0] mask_wr;
   logic [NUM_LEVELS-1:0] active;
   logic [NUM_LEVELS-1:0] level_q;
   logic [FLAT_W-1:0]     req_flat;
   logic [FLAT_W-1:0]     mask_flat;

   always_comb begin
      wslot = decode_slot(32'(bus_addr), NUM_LEVELS, MASK_BASE);
   end

   for (genvar n = 0; n < NUM_LEVELS; n++) begin : g_level
      assign req_wr[n]  = bus_we && wslot.kind == SLOT_REQ  && wslot.idx == SLOT_IDX_W'(n);
      assign mask_wr[n] = bus_we && wslot.kind == SLOT_MASK && wslot.idx == SLOT_IDX_W'(n);

      irq_level_slice #(
         .REG_W (REG_W)
      ) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .set_pulse (src_set[n*REG_W +: REG_W]),
         .req_wr    (req_wr[n]),
         .mask_wr   (mask_wr[n]),
         .wdata     (bus_wdata),
         .req_q     (req_flat[n*REG_W +: REG_W]),
         .mask_q    (mask_flat[n*REG_W +: REG_W]),
         .active    (active[n])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else begin
         level_q <= active;
      end
   end

   assign level_out = level_q;

   irq_read_mux #(
      .NUM_LEVELS (NUM_LEVELS),
      .REG_W      (REG_W),
      .ADDR_W     (ADDR_W),
      .MASK_BASE  (MASK_BASE)
   ) u_rd (
      .addr      (bus_addr),
      .req_flat  (req_flat),
      .mask_flat (mask_flat),
      .rdata     (bus_rdata)
   );

endmodule

// File: rtl/irq_bank_chk.sv
module irq_bank_chk #(
   parameter int NUM_LEVELS = 5,
   parameter int REG_W      = 32,
   parameter int ADDR_W     = 4,
   parameter int MASK_BASE  = 8,
   localparam int FLAT_W    = NUM_LEVELS * REG_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [FLAT_W-1:0]     src_set,
   input logic                  bus_we,
   input logic [ADDR_W-1:0]     bus_addr,
   input logic [REG_W-1:0]      bus_wdata,
   input logic [REG_W-1:0]      bus_rdata,
   input logic [FLAT_W-1:0]     req_flat,
   input logic [FLAT_W-1:0]     mask_flat,
   input logic [NUM_LEVELS-1:0] level_out
);

   logic hole;
   assign hole = (32'(bus_addr) >= NUM_LEVELS) &&
                 ((32'(bus_addr) < MASK_BASE) || (32'(bus_addr) >= MASK_BASE + NUM_LEVELS));

   // R2 R4
   set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_set != '0) |=> ((req_flat & $past(src_set)) == $past(src_set)));

   // R2
   no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((req_flat & ~$past(req_flat) & ~$past(src_set)) == '0));

   // R9
   hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hole |-> (bus_rdata == '0));

   for (genvar n = 0; n < NUM_LEVELS; n++) begin : g_lvl
      // R7
      lvl_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((req_flat[n*REG_W +: REG_W] & ~mask_flat[n*REG_W +: REG_W]) != '0) |=> level_out[n]);

      // R6
      lvl_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ((req_flat[n*REG_W +: REG_W] & ~mask_flat[n*REG_W +: REG_W]) == '0) |=> !level_out[n]);

      // R5
      mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(MASK_BASE + n)) |=>
            (mask_flat[n*REG_W +: REG_W] == $past(bus_wdata)));

      // R3
      clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == ADDR_W'(n)) |=>
            ((req_flat[n*REG_W +: REG_W] & $past(bus_wdata) &
              ~$past(src_set[n*REG_W +: REG_W])) == '0));
   end

endmodule

bind irq_level_bank irq_bank_chk #(
   .NUM_LEVELS (NUM_LEVELS),
   .REG_W      (REG_W),
   .ADDR_W     (ADDR_W),
   .MASK_BASE  (MASK_BASE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_set   (src_set),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .req_flat  (req_flat),
   .mask_flat (mask_flat),
   .level_out (level_out)
);

// File: tb/tb_irq_level_bank.sv
`timescale 1ns/100ps
module tb_irq_level_bank;

   localparam int NL   = 5;
   localparam int W    = 32;
   localparam int AW   = 4;
   localparam int FLAT = NL * W;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [FLAT-1:0] src_set = '0;
   logic            bus_we = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [W-1:0]    bus_wdata = '0;
   logic [W-1:0]    bus_rdata;
   logic [NL-1:0]   level_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   irq_level_bank dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_set   (src_set),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .level_out (level_out)
   );

   function automatic logic [FLAT-1:0] pulse(input int lvl, input int b);
      logic [FLAT-1:0] v = '0;
      v[lvl*W + b] = 1'b1;
      return v;
   endfunction

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic check_lvl(input string tag, input logic [NL-1:0] exp);
      check(tag, W'(level_out), W'(exp));
   endtask

   // Drive one cycle of stimulus from a falling edge; returns at the next falling edge.
   task automatic cyc(input logic [FLAT-1:0] s, input logic we,
                      input logic [AW-1:0] a, input logic [W-1:0] d);
      src_set = s; bus_we = we; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      src_set = '0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   task automatic idle();
      cyc('0, 1'b0, '0, '0);
   endtask

   // Read: sampled mid low phase, then one idle edge.
   task automatic rd(input string tag, input logic [AW-1:0] a, input logic [W-1:0] exp);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
      @(negedge clk);
   endtask

   task automatic t_reset();
      for (int i = 0; i < NL; i++) rd("R1 pending reset", AW'(i), 32'h0);
      for (int i = 0; i < NL; i++) rd("R1 blocking reset", AW'(8 + i), 32'hFFFF_FFFF);
      check_lvl("R1 level reset", 5'b0);
   endtask

   task automatic t_set();
      cyc(pulse(2, 7), 1'b0, '0, '0);
      rd("R2 level2 bit7 set", 4'd2, 32'h0000_0080);
      rd("R2 other level untouched", 4'd1, 32'h0);
      check_lvl("R6 reset blocking hides pending", 5'b0);
   endtask

   task automatic t_unblock();
      cyc('0, 1'b1, 4'd10, 32'hFFFF_FF7F);
      check_lvl("R8 level unchanged on blocking edge", 5'b0);
      rd("R5 blocking readback", 4'd10, 32'hFFFF_FF7F);
      check_lvl("R7 level2 raised", 5'b00100);
   endtask

   task automatic t_clear();
      cyc(pulse(2, 9), 1'b0, '0, '0);
      cyc('0, 1'b1, 4'd2, 32'h0000_0080);
      check_lvl("R8 level held on clear edge", 5'b00100);
      rd("R3 partial clear keeps bit9", 4'd2, 32'h0000_0200);
      check_lvl("R6 bit9 blocked so level drops", 5'b0);
   endtask

   task automatic t_set_wins();
      cyc(pulse(0, 3) | pulse(0, 4), 1'b0, '0, '0);
      rd("R2 level0 bits3,4", 4'd0, 32'h0000_0018);
      cyc(pulse(0, 3), 1'b1, 4'd0, 32'h0000_0018);
      rd("R4 set beats clear", 4'd0, 32'h0000_0008);
   endtask

   task automatic t_block();
      idle();
      check_lvl("R6 all blocked level0 quiet", 5'b0);
      cyc('0, 1'b1, 4'd8, 32'hFFFF_FFF7);
      idle();
      check_lvl("R7 level0 is bit0", 5'b00001);
      cyc('0, 1'b1, 4'd8, 32'hFFFF_FFFF);
      check_lvl("R8 level0 held one edge", 5'b00001);
      idle();
      check_lvl("R6 reblocked level0", 5'b0);
   endtask

   task automatic t_top_level();
      cyc('0, 1'b1, 4'd12, 32'h0);
      cyc(pulse(4, 31), 1'b0, '0, '0);
      check_lvl("R8 level4 not yet", 5'b0);
      idle();
      check_lvl("R7 level4 only", 5'b10000);
      cyc('0, 1'b1, 4'd4, 32'h8000_0000);
      idle();
      check_lvl("R3 level4 cleared", 5'b0);
      rd("R3 pending4 empty", 4'd4, 32'h0);
   endtask

   task automatic t_holes();
      cyc('0, 1'b1, 4'd5, 32'hFFFF_FFFF);
      cyc('0, 1'b1, 4'd6, 32'hFFFF_FFFF);
      cyc('0, 1'b1, 4'd14, 32'hFFFF_FFFF);
      cyc('0, 1'b1, 4'd15, 32'hFFFF_FFFF);
      rd("R9 offset6 zero", 4'd6, 32'h0);
      rd("R9 offset7 zero", 4'd7, 32'h0);
      rd("R9 offset13 zero", 4'd13, 32'h0);
      rd("R9 offset15 zero", 4'd15, 32'h0);
      rd("R9 blocking4 intact", 4'd12, 32'h0);
      rd("R9 pending2 intact", 4'd2, 32'h0000_0200);
      rd("R9 blocking2 intact", 4'd10, 32'hFFFF_FF7F);
      check_lvl("R9 level intact", 5'b0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set();
      t_unblock();
      t_clear();
      t_set_wins();
      t_block();
      t_top_level();
      t_holes();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule